// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits on the host side of a 1M x 16 extended-data-out DRAM. It takes single-word or single-byte read and write requests over a valid/ready handshake and turns each one into a sequence of row strobe, column strobe, write-enable and output-enable levels. Every strobe timing is a whole number of clock cycles.

A 20-bit word address is split into a 10-bit row and a 10-bit column. The two halves go out one after the other on a shared 10-bit address bus. After an access the row stays open. A later request to the same row is served as a page-mode column access without a new row strobe. A request to a different row first closes the open row and waits out the precharge time. The row strobe never stays asserted longer than a set number of cycles.

The byte-enable bits drive two column strobes, one for each byte lane. Read data is captured during column precharge, which extended data out allows. A separate refresh block can ask for the DRAM bus. The controller closes the row, waits out precharge, and grants the bus only between accesses.

Top module: `edo_page_ctrl`

## Requirements
- R1: A request's address bits 19:10 form the row and bits 9:0 form the column. The row is on `dram_addr` in the cycle the row strobe falls. The column is on `dram_addr` in the cycle a column strobe falls.
- R2: `dram_cas_n[0]` strobes data bits 7:0 and follows `req_be[0]`. `dram_cas_n[1]` strobes bits 15:8 and follows `req_be[1]`. A word access has both enable bits set, and the controller lowers only the strobes whose enable bit is 1.
- R3: In a write, `dram_we_n` is low and `dram_oe_n` is high while the column strobe is low, and `dram_dq_out` carries the write data with `dram_dq_oe` high. In a read, `dram_we_n` stays high and `dram_oe_n` is low.
- R4: When a row is opened, the column strobe falls exactly `T_RCD` cycles after the row strobe falls. It then stays low for `T_CAS` cycles and high for `T_CP` cycles.
- R5: While a row is open, a request to the same row is accepted with no row strobe activity. Its column strobe falls in the cycle after acceptance.
- R6: A request to a different row raises the row strobe in the cycle after acceptance. The row strobe stays high for exactly `T_RP` cycles, then falls with the new row on the bus. After reset, the first row strobe fall needs no precharge wait.
- R7: The row strobe is never low for more than `T_RAS_MAX` consecutive cycles. The controller closes the row on its own, even while page hits keep arriving.
- R8: For a read, `rd_valid` pulses for one cycle, `T_CAS + T_CP` cycles after the column strobe fell. `rd_data` holds `dram_dq_in` as sampled on the last cycle of column precharge.
- R9: While `ref_req` is high, no new request is accepted. Any access in flight completes, any open row is closed with full precharge, and then `ref_gnt` rises. While `ref_gnt` is high, every strobe is high and `req_ready` is low. `ref_gnt` falls in the cycle after `ref_req` falls.
- R10: After reset, all strobes, `dram_we_n` and `dram_oe_n` are high, and `dram_dq_oe`, `rd_valid` and `ref_gnt` are low. `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 20 | Word address, row in bits 19:10, column in bits 9:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane; must be nonzero |
| req_write | input | 1 | 1 for write, 0 for read |
| rd_valid | output | 1 | One-cycle pulse, read data valid |
| rd_data | output | 16 | Captured read data |
| ref_req | input | 1 | Refresh block asks for the DRAM bus |
| ref_gnt | output | 1 | DRAM bus handed to the refresh block |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per byte lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enables the data drivers |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
The bench runs a behavioural DRAM model that latches the row and column on strobe edges. It checks the exact cycle of every strobe edge against acceptance. A swapped row/column split, or a lane strobe tied to the wrong enable bit, shows up as corrupted memory contents or wrong lane data. A page hit that reopens the row, or a row miss that skips precharge, shifts the column-strobe cycle and fails the timing checks. A long run of same-row hits must force a row close without data loss; a controller that trusts hits forever would exceed the row-strobe limit. Refresh is requested both with the row open and in the middle of an access. A grant that comes early, cuts an access short, or lets a request through would show as a wrong grant cycle, a missing read pulse or a high `req_ready`.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

    localparam int ROW_W  = 10;
    localparam int COL_W  = 10;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int DQ_W   = 16;
    localparam int LANES  = DQ_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // row closed, bus free
        ST_RCD,    // row strobe low, waiting to strobe column
        ST_CASLO,  // column strobe low
        ST_CASHI,  // column precharge, read data still driven
        ST_OPEN,   // row open, waiting for next request
        ST_PRECH,  // row strobe high, precharging
        ST_REF     // bus granted to refresh block
    } edo_state_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [LANES-1:0] be;
        logic             wr;
        logic [DQ_W-1:0]  wdata;
    } edo_req_t;

    function automatic edo_req_t pack_req(input logic [ADDR_W-1:0] addr,
                                          input logic [DQ_W-1:0]   wd,
                                          input logic [LANES-1:0]  be,
                                          input logic              wr);
        edo_req_t r;
        r.row   = addr[ADDR_W-1:COL_W];
        r.col   = addr[COL_W-1:0];
        r.be    = be;
        r.wr    = wr;
        r.wdata = wd;
        return r;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/edo_cycle_timer.sv
module edo_cycle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
    parameter int RAS_MAX = 2500,
    parameter int RP      = 13,
    parameter int PAGE    = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic ras_n,
    output logic hit_ok
);
    localparam int AGE_W    = $clog2(RAS_MAX + 2);
    localparam int RP_W     = $clog2(RP + 1);
    localparam int HOLD_LIM = RAS_MAX - PAGE - 2;

    logic [AGE_W-1:0] age;   // consecutive low cycles before this one
    logic [RP_W-1:0]  hi;    // consecutive high cycles before this one, saturating

    always_ff @(posedge clk) begin
        if (rst)                                age <= '0;
        else if (ras_n)                         age <= '0;
        else if (age != AGE_W'(RAS_MAX + 1))    age <= age + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                     hi <= RP_W'(RP);
        else if (!ras_n)             hi <= '0;
        else if (hi != RP_W'(RP))    hi <= hi + 1'b1;
    end

    // a page access started now still ends before the limit
    assign hit_ok = (age <= AGE_W'(HOLD_LIM));

    p_ras_limit_r7: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> (age < AGE_W'(RAS_MAX)));

    p_precharge_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (hi == RP_W'(RP)));
endmodule

// File: rtl/edo_lane_strobe.sv
module edo_lane_strobe #(
    parameter int N = 2
) (
    input  logic         cas_on,
    input  logic [N-1:0] be,
    output logic [N-1:0] cas_n
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        assign cas_n[i] = ~(cas_on & be[i]);
    end
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
    import edo_ctrl_pkg::*;
#(
    parameter int T_RCD     = 5,
    parameter int T_CAS     = 4,
    parameter int T_CP      = 3,
    parameter int T_RP      = 13,
    parameter int T_RAS_MAX = 2500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              req_write,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    input  logic              ref_req,
    output logic              ref_gnt,
    output logic              dram_ras_n,
    output logic [LANES-1:0]  dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [PIN_W-1:0]  dram_addr,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    localparam int T_MAX = max4(T_RCD, T_CAS, T_CP, T_RP);
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int PAGE  = T_CAS + T_CP;

    edo_state_e       state, nxt;
    edo_req_t         cur;
    logic             pend;
    logic             t_load, t_done, hit_ok;
    logic [CNT_W-1:0] t_val;
    logic             accept, row_hit, ras_low, cas_on;

    edo_cycle_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
    );

    edo_ras_guard #(.RAS_MAX(T_RAS_MAX), .RP(T_RP), .PAGE(PAGE)) u_guard (
        .clk(clk), .rst(rst), .ras_n(dram_ras_n), .hit_ok(hit_ok)
    );

    edo_lane_strobe #(.N(LANES)) u_lanes (
        .cas_on(cas_on), .be(cur.be), .cas_n(dram_cas_n)
    );

    assign row_hit   = (req_addr[ADDR_W-1:COL_W] == cur.row);
    assign req_ready = !ref_req && ((state == ST_IDLE) || (state == ST_OPEN && hit_ok));
    assign accept    = req_valid && req_ready;

    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (ref_req) nxt = ST_REF;
                else if (accept) begin
                    nxt = ST_RCD;   t_load = 1'b1; t_val = CNT_W'(T_RCD - 1);
                end
            end
            ST_RCD: if (t_done) begin
                nxt = ST_CASLO; t_load = 1'b1; t_val = CNT_W'(T_CAS - 1);
            end
            ST_CASLO: if (t_done) begin
                nxt = ST_CASHI; t_load = 1'b1; t_val = CNT_W'(T_CP - 1);
            end
            ST_CASHI: if (t_done) nxt = ST_OPEN;
            ST_OPEN: begin
                if (accept && row_hit) begin
                    nxt = ST_CASLO; t_load = 1'b1; t_val = CNT_W'(T_CAS - 1);
                end else if (accept || ref_req || !hit_ok) begin
                    nxt = ST_PRECH; t_load = 1'b1; t_val = CNT_W'(T_RP - 1);
                end
            end
            ST_PRECH: if (t_done) begin
                if (pend) begin
                    nxt = ST_RCD; t_load = 1'b1; t_val = CNT_W'(T_RCD - 1);
                end else if (ref_req) nxt = ST_REF;
                else nxt = ST_IDLE;
            end
            ST_REF: if (!ref_req) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
            pend  <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) cur <= pack_req(req_addr, req_wdata, req_be, req_write);
            if (accept && state == ST_OPEN && !row_hit) pend <= 1'b1;
            else if (nxt == ST_RCD)                     pend <= 1'b0;
        end
    end

    // read capture on the last precharge cycle, data held by extended data out
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state == ST_CASHI) && t_done && !cur.wr;
            if ((state == ST_CASHI) && t_done && !cur.wr) rd_data <= dram_dq_in;
        end
    end

    assign ras_low     = (state == ST_RCD) || (state == ST_CASLO) ||
                         (state == ST_CASHI) || (state == ST_OPEN);
    assign cas_on      = (state == ST_CASLO);
    assign dram_ras_n  = !ras_low;
    assign dram_addr   = (state == ST_RCD) ? PIN_W'(cur.row) : PIN_W'(cur.col);
    assign dram_we_n   = !(cur.wr && ((state == ST_RCD) || (state == ST_CASLO)));
    assign dram_dq_oe  = cur.wr && ((state == ST_RCD) || (state == ST_CASLO));
    assign dram_dq_out = cur.wdata;
    assign dram_oe_n   = !(!cur.wr && ((state == ST_CASLO) || (state == ST_CASHI)));
    assign ref_gnt     = (state == ST_REF);

    p_cas_in_row_r4: assert property (@(posedge clk) disable iff (rst)
        (dram_cas_n != '1) |-> !dram_ras_n);

    p_write_oe_off_r3: assert property (@(posedge clk) disable iff (rst)
        !dram_we_n |-> (dram_oe_n && dram_dq_oe));

    p_we_steady_r3: assert property (@(posedge clk) disable iff (rst)
        ((dram_cas_n != '1) && $past(dram_cas_n != '1)) |-> $stable(dram_we_n));

    p_gnt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ref_gnt |-> (dram_ras_n && (dram_cas_n == '1) && !req_ready));

    p_rd_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    p_hit_no_ras_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPEN && accept && row_hit) |=> (!dram_ras_n && (dram_cas_n != '1)));
endmodule

// File: tb/edo_page_ctrl_bench.sv
module edo_page_ctrl_bench;
    localparam int T_RCD = 3, T_CAS = 2, T_CP = 2, T_RP = 4, T_RAS_MAX = 120;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        req_ready, rd_valid, ref_gnt;
    logic [15:0] rd_data, dram_dq_out;
    logic        dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [1:0]  dram_cas_n;
    logic [9:0]  dram_addr;
    logic [15:0] dq_in = 16'h0BAD;

    int n_chk = 0, n_fail = 0, cyc = 0;

    edo_page_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
                    .T_RAS_MAX(T_RAS_MAX)) u_edo_page_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_write(req_write),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // DRAM model and strobe monitor, evaluated mid-cycle
    logic [15:0] mem [logic [19:0]];
    logic        prev_ras = 1'b1;
    logic [1:0]  prev_cas = 2'b11;
    logic [9:0]  m_row = '0;
    int ras_fall_cyc = -1, ras_rise_cyc = -1, ras_rises = 0, low_run = 0, max_low = 0;
    int cas_fall_cyc = -1;
    logic [9:0] row_at_fall, col_at_fall;
    logic [1:0] lanes_at_fall;
    logic       we_at_fall, oe_at_fall, dqoe_at_fall;

    always @(negedge clk) begin
        logic [1:0]  fell;
        logic [19:0] key;
        logic [15:0] w;
        if (!dram_ras_n && prev_ras) begin
            ras_fall_cyc = cyc; m_row = dram_addr; row_at_fall = dram_addr;
        end
        if (dram_ras_n && !prev_ras) begin ras_rises++; ras_rise_cyc = cyc; end
        if (dram_ras_n) low_run = 0;
        else begin low_run++; if (low_run > max_low) max_low = low_run; end
        if (dram_oe_n) dq_in = 16'h0BAD;
        fell = prev_cas & ~dram_cas_n;
        if (fell != 2'b00) begin
            cas_fall_cyc = cyc; col_at_fall = dram_addr; lanes_at_fall = fell;
            we_at_fall = dram_we_n; oe_at_fall = dram_oe_n; dqoe_at_fall = dram_dq_oe;
            key = {m_row, dram_addr};
            w = mem.exists(key) ? mem[key] : 16'h0000;
            if (!dram_we_n) begin
                if (fell[0]) w[7:0]  = dram_dq_out[7:0];
                if (fell[1]) w[15:8] = dram_dq_out[15:8];
                mem[key] = w;
            end else begin
                if (fell[0]) dq_in[7:0]  = w[7:0];
                if (fell[1]) dq_in[15:8] = w[15:8];
            end
        end
        prev_ras = dram_ras_n;
        prev_cas = dram_cas_n;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic issue(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be,
                         input logic wr, output int acc);
        @(negedge clk);
        req_addr = a; req_wdata = d; req_be = be; req_write = wr; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        acc = cyc;
    endtask

    task automatic wait_rd(output int rc, output logic [15:0] d);
        do @(negedge clk); while (!rd_valid);
        rc = cyc; d = rd_data;
    endtask

    task automatic settle();
        repeat (T_CAS + T_CP + 3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 ras_n", dram_ras_n, 1);
        chk("R10 cas_n", dram_cas_n, 2'b11);
        chk("R10 we_n", dram_we_n, 1);
        chk("R10 oe_n", dram_oe_n, 1);
        chk("R10 dq_oe", dram_dq_oe, 0);
        chk("R10 rd_valid", rd_valid, 0);
        chk("R10 ref_gnt", ref_gnt, 0);
        chk("R10 req_ready", req_ready, 1);
    endtask

    task automatic t_random_write();
        int acc;
        issue({10'h2B5, 10'h07C}, 16'h1234, 2'b11, 1'b1, acc);
        settle();
        chk("R6 first open no precharge", ras_fall_cyc, acc);
        chk("R1 row at ras fall", row_at_fall, 10'h2B5);
        chk("R4 ras to cas delay", cas_fall_cyc, acc + T_RCD);
        chk("R1 col at cas fall", col_at_fall, 10'h07C);
        chk("R2 word lanes", lanes_at_fall, 2'b11);
        chk("R3 write we_n", we_at_fall, 0);
        chk("R3 write oe_n", oe_at_fall, 1);
        chk("R3 write dq_oe", dqoe_at_fall, 1);
        chk("R3 write data stored", mem[{10'h2B5, 10'h07C}], 16'h1234);
    endtask

    task automatic t_page_hit_read();
        int acc, rc, rises0, fall0;
        logic [15:0] d;
        rises0 = ras_rises; fall0 = ras_fall_cyc;
        issue({10'h2B5, 10'h07C}, 16'h0, 2'b11, 1'b0, acc);
        wait_rd(rc, d);
        chk("R5 hit cas cycle", cas_fall_cyc, acc);
        chk("R5 hit no ras rise", ras_rises, rises0);
        chk("R5 hit no ras fall", ras_fall_cyc, fall0);
        chk("R8 read pulse cycle", rc, acc + T_CAS + T_CP);
        chk("R8 read data", d, 16'h1234);
        chk("R3 read we_n", we_at_fall, 1);
        chk("R3 read oe_n", oe_at_fall, 0);
        @(negedge clk);
        chk("R8 single pulse", rd_valid, 0);
    endtask

    task automatic t_byte_lanes();
        int acc, rc;
        logic [15:0] d;
        issue({10'h2B5, 10'h07C}, 16'hFFAA, 2'b01, 1'b1, acc);
        settle();
        chk("R2 lower lane only", lanes_at_fall, 2'b01);
        chk("R2 lower byte write", mem[{10'h2B5, 10'h07C}], 16'h12AA);
        issue({10'h2B5, 10'h07C}, 16'h5677, 2'b10, 1'b1, acc);
        settle();
        chk("R2 upper lane only", lanes_at_fall, 2'b10);
        chk("R2 upper byte write", mem[{10'h2B5, 10'h07C}], 16'h56AA);
        issue({10'h2B5, 10'h07C}, 16'h0, 2'b10, 1'b0, acc);
        wait_rd(rc, d);
        chk("R2 upper read lane", lanes_at_fall, 2'b10);
        chk("R2 upper read data", d[15:8], 8'h56);
    endtask

    task automatic t_row_miss();
        int acc, rc, rises0;
        logic [15:0] d;
        rises0 = ras_rises;
        issue({10'h013, 10'h3FF}, 16'h0, 2'b11, 1'b0, acc);
        wait_rd(rc, d);
        chk("R6 miss closes row", ras_rises, rises0 + 1);
        chk("R6 ras rise cycle", ras_rise_cyc, acc);
        chk("R6 precharge length", ras_fall_cyc, acc + T_RP);
        chk("R1 new row", row_at_fall, 10'h013);
        chk("R1 new col", col_at_fall, 10'h3FF);
        chk("R4 cas after reopen", cas_fall_cyc, acc + T_RP + T_RCD);
        chk("R8 miss read cycle", rc, acc + T_RP + T_RCD + T_CAS + T_CP);
        chk("R8 unwritten data", d, 16'h0000);
    endtask

    task automatic t_ras_limit();
        int acc, rc, rises0, reads;
        logic [15:0] d;
        rises0 = ras_rises; reads = 0;
        for (int i = 0; i < 40; i++) begin
            issue({10'h013, 10'(i)}, 16'h0, 2'b11, 1'b0, acc);
            wait_rd(rc, d);
            reads++;
        end
        chk("R7 all reads served", reads, 40);
        chk("R7 row strobe limit", (max_low <= T_RAS_MAX), 1);
        chk("R7 forced close", (ras_rises > rises0), 1);
        chk("R7 reopened same row", row_at_fall, 10'h013);
    endtask

    task automatic t_refresh_open();
        int acc, rc, c, g;
        logic [15:0] d;
        issue({10'h100, 10'h001}, 16'h0, 2'b11, 1'b0, acc);
        wait_rd(rc, d);
        @(negedge clk);
        ref_req = 1'b1; c = cyc;
        do @(negedge clk); while (!ref_gnt);
        g = cyc;
        chk("R9 grant after precharge", g, c + T_RP + 1);
        chk("R9 row closed at grant", dram_ras_n, 1);
        req_addr = {10'h100, 10'h002}; req_be = 2'b11; req_write = 1'b0; req_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            chk("R9 no accept while granted", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        ref_req = 1'b0;
        @(negedge clk);
        chk("R9 grant drops", ref_gnt, 0);
        chk("R9 ready returns", req_ready, 1);
    endtask

    task automatic t_refresh_mid_access();
        int acc, rc, g;
        logic [15:0] d;
        issue({10'h200, 10'h005}, 16'h0, 2'b11, 1'b0, acc);
        ref_req = 1'b1;
        wait_rd(rc, d);
        chk("R9 access completes", rc, acc + T_RCD + T_CAS + T_CP);
        chk("R9 no grant during access", ref_gnt, 0);
        do @(negedge clk); while (!ref_gnt);
        g = cyc;
        chk("R9 grant after access and precharge", g, rc + T_RP + 1);
        ref_req = 1'b0;
        @(negedge clk);
        chk("R9 release", ref_gnt, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_random_write();
        t_page_hit_read();
        t_byte_lanes();
        t_row_miss();
        t_ras_limit();
        t_refresh_open();
        t_refresh_mid_access();
        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule